// File: doc/BRIEF.md
# Multi-Bank Static Memory Controller

This block turns word-sized reads and writes from an on-chip bus into cycles on an external asynchronous memory bus. The external side has a 24-bit byte address, separate 32-bit data-out and data-in paths with a drive enable, one active-low chip select per bank, active-low output and write enables, and active-low byte-lane enables. Four banks sit above the 24-bit window, picked by two address bits above it, so each bank spans 16 MB. It suits SRAM, flash, EPROM or memory-mapped I/O.

Each bank has its own port width (8, 16 or 32 bits), its own wait-state count and its own turnaround count. A 32-bit request to a narrow bank is split into two or four narrow cycles at rising addresses, lowest part first. The request side is a valid/ready handshake. Once the requester raises `req_valid`, it must hold `req_valid`, `req_write`, `req_addr` and `req_wdata` unchanged until it sees `req_ready` high at a rising edge. The block raises `req_ready` for exactly one cycle, in the last cycle of the last narrow cycle, so back-pressure lasts for the whole external access. Read data on `req_rdata` is valid in that cycle. The configuration inputs are plain levels and may change only while no request is pending.

Top module: `xmem_ctrl`

## Requirements
- R1: The bank is `req_addr[25:24]`. During an access only that bank's `mem_cs_n` bit is low, and all chip selects are high outside accesses.
- R2: The width code for bank b is `cfg_width[2b+1:2b]`: 00 means 8 bits, 01 means 16 bits, 10 means 32 bits. On a 32-bit bank a request takes one narrow cycle at address `{req_addr[23:2],2'b00}`, with `mem_bls_n` = 4'b0000.
- R3: On a 16-bit bank a request takes two narrow cycles at word address +0 and then +2, carrying the low halfword first on data bits [15:0], with `mem_bls_n` = 4'b1100.
- R4: On an 8-bit bank a request takes four narrow cycles at word address +0, +1, +2, +3, carrying the lowest byte first on data bits [7:0], with `mem_bls_n` = 4'b1110.
- R5: Each narrow read cycle keeps chip select and `mem_oe_n` low for `cfg_wait[5b+4:5b]`+1 clock cycles, and `mem_din` is captured in the last of them.
- R6: Each narrow write cycle has one setup cycle with chip select low and `mem_we_n` high, then `mem_we_n` low for wait+1 cycles, then one hold cycle with `mem_we_n` high. Address and chip select do not change while `mem_we_n` falls or rises. `mem_dout_en` is high throughout, and `mem_oe_n` and `mem_we_n` are never low together.
- R7: Between two accesses all chip selects stay high for exactly one cycle. If the bank changes, or a read is followed by a write, they stay high for `cfg_idle[4p+3:4p]`+1 cycles instead, where p is the bank of the earlier access.
- R8: `req_ready` is high for exactly one cycle per request, in the final cycle of the final narrow cycle, and `req_rdata` carries the assembled read word in that cycle.
- R9: While `req_valid` is high and `req_ready` is low, the request fields must hold steady. A transfer completes at a rising edge where both are high.
- R10: During and just after reset, chip selects, `mem_oe_n`, `mem_we_n` and `mem_bls_n` are all high, and `req_ready` and `mem_dout_en` are low. The first access after reset gets no extra idle cycles.
- R11: Width code 11 is treated as a 32-bit bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_width | input | 8 | Port-width code, 2 bits per bank |
| cfg_wait | input | 20 | Wait states, 5 bits per bank |
| cfg_idle | input | 16 | Turnaround cycles, 4 bits per bank |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request done / accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 26 | Bank (top 2 bits) and byte address |
| req_wdata | input | 32 | Write word |
| req_rdata | output | 32 | Read word, valid with req_ready |
| mem_addr | output | 24 | External byte address |
| mem_dout | output | 32 | External write data |
| mem_dout_en | output | 1 | Drive enable for mem_dout |
| mem_din | input | 32 | External read data |
| mem_cs_n | output | 4 | Per-bank chip selects, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bls_n | output | 4 | Byte-lane enables, active low |

## Verification
Two things meet at one edge. The completion of one access, where `req_ready` is high and the turnaround record is updated, shares that edge with the decision on how many idle cycles the next request needs. The bench provokes this by issuing requests back to back, so the next request is presented in the cycle right after the handshake. It mixes same-bank, bank-switching, read-after-write and write-after-read pairs. It judges the result by counting deselected cycles before the first chip select of each request and comparing that count with 1, or with the earlier bank's idle setting plus 1.

// File: rtl/xmc_pkg.sv
package xmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD
  } xmc_state_e;

  localparam logic [1:0] WID_8  = 2'b00;
  localparam logic [1:0] WID_16 = 2'b01;

  // log2 of bytes carried per narrow cycle; codes 10 and 11 mean full width
  function automatic int lane_lg2(input logic [1:0] w, input int full_lg);
    case (w)
      WID_8:   return 0;
      WID_16:  return 1;
      default: return full_lg;
    endcase
  endfunction
endpackage

// File: rtl/xmc_bank_sel.sv
module xmc_bank_sel #(
  parameter int NBANK = 4,
  parameter int WAITW = 5,
  localparam int BKW = $clog2(NBANK)
) (
  input  logic [BKW-1:0]         sel,
  input  logic [2*NBANK-1:0]     cfg_width,
  input  logic [WAITW*NBANK-1:0] cfg_wait,
  output logic [1:0]             width,
  output logic [WAITW-1:0]       wait_cyc,
  output logic [NBANK-1:0]       onehot
);
  assign width    = cfg_width[sel*2 +: 2];
  assign wait_cyc = cfg_wait[sel*WAITW +: WAITW];

  for (genvar g = 0; g < NBANK; g++) begin : g_dec
    assign onehot[g] = (sel == BKW'(g));
  end
endmodule

// File: rtl/xmc_lane_map.sv
module xmc_lane_map
  import xmc_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32,
  localparam int NLANE = DW / 8,
  localparam int LGL = $clog2(NLANE)
) (
  input  logic [1:0]        width,
  input  logic [LGL-1:0]    beat,
  input  logic [AW-LGL-1:0] word_addr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     mem_din,
  input  logic [DW-1:0]     rbuf,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_dout,
  output logic [NLANE-1:0]  lane_en,
  output logic [LGL-1:0]    beats_m1,
  output logic [DW-1:0]     rmerge
);
  int             lg;
  logic [LGL-1:0] offs;
  logic [DW-1:0]  lane_bits;

  always_comb begin
    lg       = lane_lg2(width, LGL);
    offs     = LGL'(int'(beat) << lg);
    beats_m1 = LGL'((NLANE >> lg) - 1);
    lane_en  = NLANE'((1 << (1 << lg)) - 1);
    for (int i = 0; i < NLANE; i++) lane_bits[8*i +: 8] = {8{lane_en[i]}};
    mem_dout = wdata >> (8 * int'(offs));
    rmerge   = rbuf | ((mem_din & lane_bits) << (8 * int'(offs)));
  end

  assign mem_addr = {word_addr, offs};
endmodule

// File: rtl/xmem_ctrl.sv
module xmem_ctrl
  import xmc_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int AW    = 24,
  parameter int DW    = 32,
  parameter int WAITW = 5,
  parameter int IDLEW = 4,
  localparam int BKW   = $clog2(NBANK),
  localparam int NLANE = DW / 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2*NBANK-1:0]     cfg_width,
  input  logic [WAITW*NBANK-1:0] cfg_wait,
  input  logic [IDLEW*NBANK-1:0] cfg_idle,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [AW+BKW-1:0]      req_addr,
  input  logic [DW-1:0]          req_wdata,
  output logic [DW-1:0]          req_rdata,
  output logic [AW-1:0]          mem_addr,
  output logic [DW-1:0]          mem_dout,
  output logic                   mem_dout_en,
  input  logic [DW-1:0]          mem_din,
  output logic [NBANK-1:0]       mem_cs_n,
  output logic                   mem_oe_n,
  output logic                   mem_we_n,
  output logic [NLANE-1:0]       mem_bls_n
);
  localparam int LGL = $clog2(NLANE);

  xmc_state_e       state;
  logic [WAITW-1:0] cnt;
  logic [LGL-1:0]   beat;
  logic [DW-1:0]    rbuf;
  logic             have_prev, prev_read;
  logic [BKW-1:0]   prev_bank;

  logic [BKW-1:0]   bank;
  logic [1:0]       width;
  logic [WAITW-1:0] wait_cyc;
  logic [NBANK-1:0] onehot;
  logic [NLANE-1:0] lane_en;
  logic [LGL-1:0]   beats_m1;
  logic [DW-1:0]    rmerge;
  logic [IDLEW-1:0] prev_idle;
  logic             need_gap, last, active;

  assign bank = req_addr[AW+BKW-1:AW];

  xmc_bank_sel #(.NBANK(NBANK), .WAITW(WAITW)) u_sel (
    .sel(bank), .cfg_width(cfg_width), .cfg_wait(cfg_wait),
    .width(width), .wait_cyc(wait_cyc), .onehot(onehot)
  );

  xmc_lane_map #(.AW(AW), .DW(DW)) u_lanes (
    .width(width), .beat(beat), .word_addr(req_addr[AW-1:LGL]),
    .wdata(req_wdata), .mem_din(mem_din), .rbuf(rbuf),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .lane_en(lane_en),
    .beats_m1(beats_m1), .rmerge(rmerge)
  );

  assign prev_idle = cfg_idle[prev_bank*IDLEW +: IDLEW];
  assign need_gap  = have_prev && ((bank != prev_bank) || (prev_read && req_write));
  assign last      = (beat == beats_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      beat      <= '0;
      rbuf      <= '0;
      have_prev <= 1'b0;
      prev_read <= 1'b0;
      prev_bank <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          beat <= '0;
          rbuf <= '0;
          if (need_gap && prev_idle != '0) begin
            state <= ST_GAP;
            cnt   <= WAITW'(prev_idle) - 1'b1;
          end else begin
            state <= req_write ? ST_SETUP : ST_STROBE;
            cnt   <= wait_cyc;
          end
        end
        ST_GAP: begin
          if (cnt == '0) begin
            state <= req_write ? ST_SETUP : ST_STROBE;
            cnt   <= wait_cyc;
          end else cnt <= cnt - 1'b1;
        end
        ST_SETUP: begin
          state <= ST_STROBE;
          cnt   <= wait_cyc;
        end
        ST_STROBE: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (req_write) state <= ST_HOLD;
          else begin
            rbuf <= rmerge;
            if (last) begin
              state     <= ST_IDLE;
              have_prev <= 1'b1;
              prev_bank <= bank;
              prev_read <= 1'b1;
            end else begin
              beat <= beat + 1'b1;
              cnt  <= wait_cyc;
            end
          end
        end
        ST_HOLD: begin
          if (last) begin
            state     <= ST_IDLE;
            have_prev <= 1'b1;
            prev_bank <= bank;
            prev_read <= 1'b0;
          end else begin
            beat  <= beat + 1'b1;
            state <= ST_SETUP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign active      = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
  assign mem_cs_n    = active ? ~onehot : '1;
  assign mem_bls_n   = active ? ~lane_en : '1;
  assign mem_oe_n    = !((state == ST_STROBE) && !req_write);
  assign mem_we_n    = !((state == ST_STROBE) && req_write);
  assign mem_dout_en = active && req_write;
  assign req_ready   = ((state == ST_STROBE) && !req_write && cnt == '0 && last) ||
                       ((state == ST_HOLD) && last);
  assign req_rdata   = rmerge;
endmodule

// File: rtl/xmem_ctrl_chk.sv
module xmem_ctrl_chk #(
  parameter int NBANK = 4,
  parameter int AW    = 24,
  parameter int DW    = 32,
  localparam int BKW  = $clog2(NBANK)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [AW+BKW-1:0] req_addr,
  input logic [DW-1:0]     req_wdata,
  input logic [AW-1:0]     mem_addr,
  input logic              mem_dout_en,
  input logic [NBANK-1:0]  mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n
);
  a_r1_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  a_r5_oe_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_cs_n != '1));

  a_r6_we_fall_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $stable(mem_addr) && $stable(mem_cs_n));

  a_r6_we_rise_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> $stable(mem_addr) && $stable(mem_cs_n) && (mem_cs_n != '1));

  a_r6_no_oe_we_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  a_r6_data_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dout_en);

  a_r8_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  a_r8_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);

  a_r9_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid && $stable(req_addr) &&
                                  $stable(req_write) && $stable(req_wdata));
endmodule

bind xmem_ctrl xmem_ctrl_chk #(.NBANK(NBANK), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/xmem_ctrl_test.sv
module xmem_ctrl_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_width;
  logic [19:0] cfg_wait;
  logic [15:0] cfg_idle;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [25:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, mem_dout_en, mem_oe_n, mem_we_n;
  logic [31:0] req_rdata, mem_dout, mem_din;
  logic [23:0] mem_addr;
  logic [3:0]  mem_cs_n, mem_bls_n;

  logic [1:0] cw [4];
  logic [4:0] cwt [4];
  logic [3:0] cid [4];
  logic [7:0] mem [4][64];
  logic [7:0] ref_mem [4][64];

  int nchecks = 0, nerr = 0;
  bit bhave = 0, bprev_rd = 0;
  logic [1:0] bprev = 0;

  always #(CLK_NS/2) clk = ~clk;

  always_comb
    for (int b = 0; b < 4; b++) begin
      cfg_width[2*b +: 2] = cw[b];
      cfg_wait[5*b +: 5]  = cwt[b];
      cfg_idle[4*b +: 4]  = cid[b];
    end

  xmem_ctrl uut (.*);

  function automatic int sel_bank(input logic [3:0] cs);
    for (int b = 0; b < 4; b++) if (!cs[b]) return b;
    return 0;
  endfunction

  // external memory model: lane i maps to byte mem_addr+i
  always @(posedge clk)
    if (!mem_we_n)
      for (int i = 0; i < 4; i++)
        if (!mem_bls_n[i])
          mem[sel_bank(mem_cs_n)][6'(mem_addr[5:0] + 6'(i))] <= mem_dout[8*i +: 8];

  always @* begin
    mem_din = '0;
    if (mem_cs_n != 4'hF)
      for (int i = 0; i < 4; i++)
        mem_din[8*i +: 8] = mem[sel_bank(mem_cs_n)][6'(mem_addr[5:0] + 6'(i))];
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [1:0] bk, input logic [23:0] a, input logic [31:0] d);
    int lg, bytes, beats, wt, gap_exp, hi, lo, welo, steps, badstep, badcs, badbls;
    bit first, done;
    logic [23:0] fa, lasta;
    logic [31:0] got, expw;
    string wname;
    lg = (cw[bk] == 2'b00) ? 0 : (cw[bk] == 2'b01) ? 1 : 2;
    wname = (lg == 0) ? "R4 8-bit split" : (lg == 1) ? "R3 16-bit split" :
            (cw[bk] == 2'b11) ? "R11 code 11 as 32-bit" : "R2 32-bit";
    bytes = 1 << lg; beats = 4 >> lg; wt = int'(cwt[bk]);
    gap_exp = (bhave && (bk != bprev || (bprev_rd && wr))) ? int'(cid[bprev]) : 0;
    for (int i = 0; i < 4; i++) expw[8*i +: 8] = ref_mem[bk][6'(a[5:0] + 6'(i))];
    if (wr) for (int i = 0; i < 4; i++) ref_mem[bk][6'(a[5:0] + 6'(i))] = d[8*i +: 8];
    hi = 0; lo = 0; welo = 0; steps = 0; badstep = 0; badcs = 0; badbls = 0;
    first = 1; done = 0; fa = '0; lasta = '0; got = '0;
    // R9: fields stay put from here until the handshake
    req_write = wr; req_addr = {bk, a}; req_wdata = d; req_valid = 1'b1;
    for (int g = 0; g < 1000; g++) begin
      if (mem_cs_n == 4'hF) begin
        if (lo == 0) hi++;
      end else begin
        if (mem_cs_n != ~(4'b0001 << bk)) badcs++;
        if (mem_bls_n != ~4'((1 << bytes) - 1)) badbls++;
        if (!mem_we_n) welo++;
        if (first) begin fa = mem_addr; first = 0; end
        else if (mem_addr != lasta) begin
          steps++;
          if (mem_addr != lasta + 24'(bytes)) badstep++;
        end
        lasta = mem_addr; lo++;
      end
      if (req_ready) begin got = req_rdata; done = 1; break; end
      @(negedge clk);
    end
    chk(done, "R8 request completes", 32'(done), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R8 ready one cycle", 32'(req_ready), 0);
    chk(badcs == 0, "R1 chip select of bank", badcs, 0);
    chk(fa == {a[23:2], 2'b00}, {wname, " first address"}, 32'(fa), 32'({a[23:2], 2'b00}));
    chk(steps == beats - 1 && badstep == 0, {wname, " narrow cycle count"}, steps, beats - 1);
    chk(badbls == 0, {wname, " lane enables"}, badbls, 0);
    chk(hi == 1 + gap_exp, "R7 deselected cycles", hi, 1 + gap_exp);
    if (wr) begin
      chk(lo == beats * (wt + 3), "R6 write select length", lo, beats * (wt + 3));
      chk(welo == beats * (wt + 1), "R6 write strobe length", welo, beats * (wt + 1));
    end else begin
      chk(lo == beats * (wt + 1), "R5 read strobe length", lo, beats * (wt + 1));
      chk(got == expw, "R8 read data", got, expw);
    end
    bhave = 1; bprev = bk; bprev_rd = !wr;
  endtask

  initial begin
    #(CLK_NS * 190000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    cw[0] = 2'b10; cw[1] = 2'b01; cw[2] = 2'b00; cw[3] = 2'b11;
    cwt[0] = 5'd0; cwt[1] = 5'd2; cwt[2] = 5'd31; cwt[3] = 5'd1;
    cid[0] = 4'd15; cid[1] = 4'd3; cid[2] = 4'd0; cid[3] = 4'd7;
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 64; i++) begin
        mem[b][i] = 8'($urandom);
        ref_mem[b][i] = mem[b][i];
      end
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(mem_cs_n == 4'hF && mem_bls_n == 4'hF, "R10 selects idle in reset", {mem_cs_n, mem_bls_n}, 8'hFF);
    chk(mem_oe_n && mem_we_n, "R10 strobes idle in reset", {mem_oe_n, mem_we_n}, 2'b11);
    chk(!req_ready && !mem_dout_en, "R10 ready and drive low", {req_ready, mem_dout_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_cs_n == 4'hF && !req_ready, "R10 idle after reset", {req_ready, mem_cs_n}, 4'hF);
    // directed corner cases (first access: no extra gap)
    xfer(1, 2'd0, 24'h000010, 32'hA1B2C3D4);
    xfer(0, 2'd0, 24'h000010, 32'h0);          // write then read: 1 cycle
    xfer(0, 2'd0, 24'h000014, 32'h0);          // read then read: 1 cycle
    xfer(1, 2'd0, 24'h000014, 32'h11223344);   // read then write: idle 15
    xfer(1, 2'd2, 24'hFFFF20, 32'hCAFEF00D);   // bank switch, 8-bit, wait 31
    xfer(0, 2'd2, 24'hFFFF20, 32'h0);
    xfer(1, 2'd1, 24'h123438, 32'h5A5AA5A5);   // 16-bit
    xfer(0, 2'd1, 24'h123438, 32'h0);
    xfer(1, 2'd3, 24'h00003C, 32'hDEADBEEF);   // width code 11
    xfer(0, 2'd3, 24'h00003C, 32'h0);
    // constrained random traffic
    for (int n = 0; n < 300; n++) begin
      if (n % 25 == 0)
        for (int b = 0; b < 4; b++) begin
          cw[b] = 2'($urandom);
          cwt[b] = ($urandom % 4 == 0) ? 5'($urandom) : 5'($urandom % 4);
          cid[b] = 4'($urandom);
        end
      repeat ($urandom % 3) @(negedge clk);
      xfer(1'($urandom), 2'($urandom), {18'($urandom), 6'($urandom) & 6'h3C}, $urandom);
    end
    $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
    $finish;
  end
endmodule